// File: doc/BRIEF.md
# ECC Word Store with Byte Merge

This block keeps data as 32-bit words, each stored beside 6 check bits of a Hamming single-error-correcting code, and presents a one-byte-at-a-time read and write interface to the serial protocol engine in front of it. A read fetches the whole word, repairs any single flipped bit (in the data or in the check bits), and returns the selected byte. A write fetches and repairs the word, replaces one byte, recomputes the check bits and writes all four bytes and the check bits back as one codeword.

Every fetch whose syndrome is non-zero raises a one-cycle correction flag. A test port flips one chosen bit of one stored codeword so that the correction path can be exercised. The storage is a plain register array cleared by reset; an all-zero codeword is valid.

Top module: `ecc_word_store`

## Requirements
- R1: After reset, busy, rd_valid and corrected are low, and every byte reads back as 0x00 with corrected low.
- R2: Byte address bits [1:0] select the lane inside a word, lane 0 being data bits [7:0] and lane 3 bits [31:24]; the upper address bits select the word.
- R3: A request is accepted on a rising edge where req_valid is high and busy is low; for a read, busy is high for the following cycle and rd_valid is high for exactly one cycle after the second edge, with rd_data holding the addressed byte and busy low.
- R4: An accepted write keeps busy high for exactly three cycles and never raises rd_valid; later reads return the new byte and the other three bytes of the word unchanged.
- R5: req_valid while busy is high is ignored: no extra result appears and stored data does not change.
- R6: A single flipped data bit is corrected in the returned byte, and corrected is high together with rd_valid for that read.
- R7: A single flipped check bit (injection index 32 to 37, check bit index minus 32) leaves the returned data intact and still raises corrected.
- R8: A write rewrites the whole word from corrected data with fresh check bits, so a stored single-bit error in that word is removed.
- R9: An injection index of 38 or more changes nothing: a later read returns correct data with corrected low.
- R10: A read of an undisturbed word keeps corrected low.
- R11: On a write, corrected reports the fetch syndrome one cycle after acceptance (the cycle after the accepting edge is followed by the flag).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request strobe |
| req_write | input | 1 | 1 = byte write, 0 = byte read |
| req_addr | input | ADDR_W | Byte address |
| req_wdata | input | 8 | Byte to write |
| busy | output | 1 | Operation in progress, requests ignored |
| rd_valid | output | 1 | One-cycle read result strobe |
| rd_data | output | 8 | Byte read |
| corrected | output | 1 | One-cycle flag: fetch syndrome was non-zero |
| inj_en | input | 1 | Test: flip one stored bit this cycle |
| inj_word | input | ADDR_W-2 | Test: word index to disturb |
| inj_bit | input | 6 | Test: codeword bit, 0-31 data, 32-37 check |

## Verification
The hard case is a stored word that is already corrupted when a write merges into it, because through the ports alone every stored word is always a valid codeword. The bench uses the injection port to plant data-bit and check-bit flips, reads them back to see the repair and the flag, then writes another byte of the same word and reads a neighbouring byte to show the error was scrubbed. Requests held high during a write's busy window show that nothing extra is accepted.

// File: rtl/ecc_store_pkg.sv
package ecc_store_pkg;
  localparam int DATA_W = 32;
  localparam int CHK_W  = 6;
  localparam int CODE_W = DATA_W + CHK_W;
  localparam int LANE_W = 8;
  localparam int LANES  = DATA_W / LANE_W;

  typedef enum logic [1:0] {ST_IDLE, ST_FETCH, ST_MERGE, ST_COMMIT} st_e;

  // Hamming positions 1..CODE_W; powers of two hold check bits, the rest
  // hold data bits in ascending order.
  function automatic logic [CHK_W-1:0] ecc_check(input logic [DATA_W-1:0] d);
    logic [CHK_W-1:0] c;
    int idx;
    c   = '0;
    idx = 0;
    for (int p = 1; p <= CODE_W; p++) begin
      if ((p & (p - 1)) != 0) begin
        for (int k = 0; k < CHK_W; k++) begin
          if (p[k]) c[k] = c[k] ^ d[idx[4:0]];
        end
        idx++;
      end
    end
    return c;
  endfunction

  function automatic logic [DATA_W-1:0] ecc_fix(input logic [DATA_W-1:0] d,
                                                input logic [CHK_W-1:0] syn);
    logic [DATA_W-1:0] r;
    int idx;
    r   = d;
    idx = 0;
    for (int p = 1; p <= CODE_W; p++) begin
      if ((p & (p - 1)) != 0) begin
        if (p[CHK_W-1:0] == syn) r[idx[4:0]] = ~r[idx[4:0]];
        idx++;
      end
    end
    return r;
  endfunction
endpackage

// File: rtl/ecc_encode.sv
module ecc_encode
  import ecc_store_pkg::*;
(
  input  logic [DATA_W-1:0] data,
  output logic [CHK_W-1:0]  chk
);
  always_comb chk = ecc_check(data);
endmodule

// File: rtl/ecc_correct.sv
module ecc_correct
  import ecc_store_pkg::*;
(
  input  logic [CODE_W-1:0] code,
  output logic [DATA_W-1:0] fixed,
  output logic              err
);
  logic [CHK_W-1:0] syn;

  always_comb begin
    syn   = ecc_check(code[DATA_W-1:0]) ^ code[CODE_W-1:DATA_W];
    fixed = ecc_fix(code[DATA_W-1:0], syn);
    err   = |syn;
  end
endmodule

// File: rtl/ecc_word_bank.sv
module ecc_word_bank
  import ecc_store_pkg::*;
#(
  parameter int WORDS = 64,
  parameter int AW    = $clog2(WORDS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [AW-1:0]     wr_idx,
  input  logic [CODE_W-1:0] wr_code,
  input  logic              inj_en,
  input  logic [AW-1:0]     inj_idx,
  input  logic [5:0]        inj_bit,
  input  logic [AW-1:0]     rd_idx,
  output logic [CODE_W-1:0] rd_code
);
  logic [CODE_W-1:0] cells [WORDS];

  for (genvar w = 0; w < WORDS; w++) begin : g_word
    logic [CODE_W-1:0] cell_q, cell_d;
    logic              wr_hit, inj_hit, cell_we;

    always_comb begin
      wr_hit  = wr_en && (wr_idx == AW'(w));
      inj_hit = inj_en && (inj_idx == AW'(w)) && (inj_bit < 6'(CODE_W));
      cell_we = wr_hit || inj_hit;
      cell_d  = cell_q;
      if (inj_hit) cell_d[inj_bit] = ~cell_q[inj_bit];
      if (wr_hit)  cell_d = wr_code;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       cell_q <= '0;
      else if (cell_we) cell_q <= cell_d;
    end

    assign cells[w] = cell_q;
  end

  assign rd_code = cells[rd_idx];
endmodule

// File: rtl/ecc_word_store.sv
module ecc_word_store
  import ecc_store_pkg::*;
#(
  parameter  int ADDR_W  = 8,
  localparam int WORD_AW = ADDR_W - 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               req_valid,
  input  logic               req_write,
  input  logic [ADDR_W-1:0]  req_addr,
  input  logic [LANE_W-1:0]  req_wdata,
  output logic               busy,
  output logic               rd_valid,
  output logic [LANE_W-1:0]  rd_data,
  output logic               corrected,
  input  logic               inj_en,
  input  logic [WORD_AW-1:0] inj_word,
  input  logic [5:0]         inj_bit
);
  localparam int WORDS = 2 ** WORD_AW;

  st_e               state_q, state_d;
  logic              accept;
  logic [WORD_AW-1:0] widx_q;
  logic [1:0]        lane_q;
  logic [LANE_W-1:0] wdata_q;
  logic              write_q;
  logic [DATA_W-1:0] word_q;
  logic [CODE_W-1:0] code_q;
  logic [LANE_W-1:0] rd_data_q;
  logic              rd_valid_q, corr_q;

  logic [CODE_W-1:0] bank_code;
  logic [DATA_W-1:0] fix_data, merged;
  logic              fix_err;
  logic [CHK_W-1:0]  merged_chk;
  logic              fetch_en, merge_en, commit_en;

  // control
  assign accept    = (state_q == ST_IDLE) && req_valid;
  assign fetch_en  = (state_q == ST_FETCH);
  assign merge_en  = (state_q == ST_MERGE);
  assign commit_en = (state_q == ST_COMMIT);

  always_comb begin
    state_d = state_q;
    case (state_q)
      ST_IDLE:   if (req_valid) state_d = ST_FETCH;
      ST_FETCH:  state_d = write_q ? ST_MERGE : ST_IDLE;
      ST_MERGE:  state_d = ST_COMMIT;
      ST_COMMIT: state_d = ST_IDLE;
      default:   state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= ST_IDLE;
    else        state_q <= state_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      widx_q  <= '0;
      lane_q  <= '0;
      wdata_q <= '0;
      write_q <= 1'b0;
    end else if (accept) begin
      widx_q  <= req_addr[ADDR_W-1:2];
      lane_q  <= req_addr[1:0];
      wdata_q <= req_wdata;
      write_q <= req_write;
    end
  end

  // storage and code path
  ecc_word_bank #(.WORDS(WORDS), .AW(WORD_AW)) u_bank (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (commit_en),
    .wr_idx  (widx_q),
    .wr_code (code_q),
    .inj_en  (inj_en),
    .inj_idx (inj_word),
    .inj_bit (inj_bit),
    .rd_idx  (widx_q),
    .rd_code (bank_code)
  );

  ecc_correct u_fix (
    .code  (bank_code),
    .fixed (fix_data),
    .err   (fix_err)
  );

  for (genvar l = 0; l < LANES; l++) begin : g_lane
    assign merged[l*LANE_W +: LANE_W] =
      (lane_q == 2'(l)) ? wdata_q : word_q[l*LANE_W +: LANE_W];
  end

  ecc_encode u_enc (
    .data (merged),
    .chk  (merged_chk)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        word_q <= '0;
    else if (fetch_en) word_q <= fix_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        code_q <= '0;
    else if (merge_en) code_q <= {merged_chk, merged};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                     rd_data_q <= '0;
    else if (fetch_en && !write_q)  rd_data_q <= fix_data[{lane_q, 3'b000} +: LANE_W];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_valid_q <= 1'b0;
      corr_q     <= 1'b0;
    end else begin
      rd_valid_q <= fetch_en && !write_q;
      corr_q     <= fetch_en && fix_err;
    end
  end

  assign busy      = (state_q != ST_IDLE);
  assign rd_valid  = rd_valid_q;
  assign rd_data   = rd_data_q;
  assign corrected = corr_q;
endmodule

// File: rtl/ecc_word_store_chk.sv
module ecc_word_store_chk (
  input logic clk,
  input logic rst_n,
  input logic req_valid,
  input logic req_write,
  input logic busy,
  input logic rd_valid,
  input logic corrected
);
  p_read_latency_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && req_valid && !req_write) |=> busy ##1 (rd_valid && !busy));

  p_valid_pulse_r3: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid |=> !rd_valid);

  p_valid_idle_r3: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid |-> !busy);

  p_write_busy_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && req_valid && req_write) |=> busy ##1 busy ##1 busy ##1 !busy);

  p_write_no_valid_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && req_valid && req_write) |=> ##1 !rd_valid);

  p_busy_no_accept_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && req_valid && !$past(!busy && req_valid)) |=> !rd_valid);

  p_corr_pulse_r6: assert property (@(posedge clk) disable iff (!rst_n)
    corrected |=> !corrected);
endmodule

bind ecc_word_store ecc_word_store_chk u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .req_valid (req_valid),
  .req_write (req_write),
  .busy      (busy),
  .rd_valid  (rd_valid),
  .corrected (corrected)
);

// File: tb/test_ecc_word_store.sv
module test_ecc_word_store;
  localparam int CLK_PERIOD = 10;
  localparam int ADDR_W = 8;

  logic clk, rst_n;
  logic req_valid, req_write;
  logic [ADDR_W-1:0] req_addr;
  logic [7:0] req_wdata;
  logic busy, rd_valid, corrected;
  logic [7:0] rd_data;
  logic inj_en;
  logic [ADDR_W-3:0] inj_word;
  logic [5:0] inj_bit;

  ecc_word_store #(.ADDR_W(ADDR_W)) i_ecc_word_store (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
    .req_addr(req_addr), .req_wdata(req_wdata), .busy(busy),
    .rd_valid(rd_valid), .rd_data(rd_data), .corrected(corrected),
    .inj_en(inj_en), .inj_word(inj_word), .inj_bit(inj_bit)
  );

  typedef struct { logic [7:0] d; logic c; string tag; } exp_t;
  exp_t exp_q[$];
  logic [7:0] mdl [256];
  int n_chk = 0, n_fail = 0;
  bit done = 0;

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic chk(string tag, string what, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  // monitor: pops the scoreboard on every read result
  always @(negedge clk) begin
    if (rst_n && rd_valid) begin
      if (exp_q.size() == 0) begin
        n_chk++; n_fail++;
        $display("FAIL R5 unexpected rd_valid: actual %0h expected none", rd_data);
      end else begin
        exp_t e;
        e = exp_q.pop_front();
        chk(e.tag, "rd_data", 32'(rd_data), 32'(e.d));
        chk(e.tag, "corrected", 32'(corrected), 32'(e.c));
      end
    end
  end

  task automatic do_read(input logic [7:0] a, input logic ec, input string tag);
    exp_t e;
    @(negedge clk);
    req_valid = 1'b1; req_write = 1'b0; req_addr = a;
    e.d = mdl[a]; e.c = ec; e.tag = tag;
    exp_q.push_back(e);
    @(negedge clk);
    req_valid = 1'b0;
    chk("R3", "busy in fetch", 32'(busy), 32'd1);
    @(negedge clk);
    chk("R3", "busy after read", 32'(busy), 32'd0);
  endtask

  task automatic do_write(input logic [7:0] a, input logic [7:0] d, input logic ec);
    @(negedge clk);
    req_valid = 1'b1; req_write = 1'b1; req_addr = a; req_wdata = d;
    @(negedge clk);
    req_valid = 1'b0;
    chk("R4", "busy c1", 32'(busy), 32'd1);
    @(negedge clk);
    chk("R4", "busy c2", 32'(busy), 32'd1);
    chk("R11", "write fetch corrected", 32'(corrected), 32'(ec));
    @(negedge clk);
    chk("R4", "busy c3", 32'(busy), 32'd1);
    @(negedge clk);
    chk("R4", "busy released", 32'(busy), 32'd0);
    mdl[a] = d;
  endtask

  task automatic inject(input logic [5:0] w, input logic [5:0] b);
    @(negedge clk);
    inj_en = 1'b1; inj_word = w; inj_bit = b;
    @(negedge clk);
    inj_en = 1'b0;
  endtask

  task automatic summary;
    if (!done) begin
      done = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
    end
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual hung expected completion");
    summary();
    $finish;
  end

  initial begin
    foreach (mdl[i]) mdl[i] = 8'h00;
    req_valid = 0; req_write = 0; req_addr = '0; req_wdata = '0;
    inj_en = 0; inj_word = '0; inj_bit = '0;
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk("R1", "busy", 32'(busy), 32'd0);
    chk("R1", "rd_valid", 32'(rd_valid), 32'd0);
    chk("R1", "corrected", 32'(corrected), 32'd0);
    do_read(8'h00, 1'b0, "R1");
    do_read(8'h05, 1'b0, "R1");
    do_read(8'hFF, 1'b0, "R1");

    // R2 lanes, R4 writes
    do_write(8'h10, 8'hA1, 1'b0);
    do_write(8'h11, 8'hB2, 1'b0);
    do_write(8'h12, 8'hC3, 1'b0);
    do_write(8'h13, 8'hD4, 1'b0);
    do_read(8'h10, 1'b0, "R2");
    do_read(8'h11, 1'b0, "R2");
    do_read(8'h12, 1'b0, "R2");
    do_read(8'h13, 1'b0, "R2");
    do_write(8'h11, 8'h5E, 1'b0);
    do_read(8'h10, 1'b0, "R4");
    do_read(8'h11, 1'b0, "R4");
    do_read(8'h12, 1'b0, "R4");

    // R5 requests during a write are ignored
    @(negedge clk);
    req_valid = 1'b1; req_write = 1'b1; req_addr = 8'h20; req_wdata = 8'h77;
    @(negedge clk);
    req_addr = 8'h10; req_wdata = 8'hFF;
    @(negedge clk);
    req_write = 1'b0;
    @(negedge clk);
    req_valid = 1'b0;
    @(negedge clk);
    chk("R5", "busy released", 32'(busy), 32'd0);
    mdl[8'h20] = 8'h77;
    do_read(8'h10, 1'b0, "R5");
    do_read(8'h20, 1'b0, "R5");

    // R6 data-bit flips
    inject(6'd4, 6'd9);
    do_read(8'h11, 1'b1, "R6");
    do_read(8'h10, 1'b1, "R6");
    inject(6'd8, 6'd0);
    do_read(8'h20, 1'b1, "R6");

    // R7 check-bit flip
    do_write(8'h14, 8'h99, 1'b0);
    inject(6'd5, 6'd35);
    do_read(8'h14, 1'b1, "R7");

    // R8 scrub on write, R11 flag on write fetch
    do_write(8'h13, 8'h3C, 1'b1);
    do_read(8'h11, 1'b0, "R8");
    do_read(8'h13, 1'b0, "R8");

    // R9 out-of-range injection
    inject(6'd4, 6'd40);
    do_read(8'h12, 1'b0, "R9");

    // R10 clean read elsewhere
    do_read(8'h00, 1'b0, "R10");

    repeat (4) @(negedge clk);
    if (exp_q.size() != 0) begin
      n_chk++; n_fail++;
      $display("FAIL R3 missing results: actual %0d pending expected 0", exp_q.size());
    end
    summary();
    $finish;
  end
endmodule